// File: doc/BRIEF.md
# UART Interrupt Identification and Status Logic

This block holds the interrupt-related registers of a 16550-style serial port. It covers the interrupt enable register, the interrupt identification register, the line status register and the modem status register. The receive FIFO, the transmit path and the modem pins feed it with level and strobe inputs. A byte-wide register bus reads and writes it. It combines the enabled sources into one interrupt line and a prioritised 3-bit identification code.

Reads have side effects. Reading the line status register clears its sticky error bits. Reading the modem status register clears its change flags. Reading the identification register while it reports "transmit holding empty" withdraws that indication. Register reads are combinational from the address. Side effects and all state updates take effect on the clock edge that ends the read cycle.

Top module: `uart_intr_ident`

## Requirements
- R1: After reset the enable register reads 0x00 and the identification register reads 0x01. The interrupt output is low. The line status error bits and the modem change flags are all zero.
- R2: A write to offset 1 stores data bits 3:0 as the enables: bit 0 receive data, bit 1 transmit holding empty, bit 2 line status, bit 3 modem status. A read of offset 1 returns those four bits, with bits 7:4 reading as zero.
- R3: Offset 2 reads the identification code in bits 2:0, with bits 7:3 zero. The code is 110 for line status, 100 for receive data, 010 for transmit holding empty and 000 for modem status. When several enabled sources are active, the code for the highest of these four (in that order) is shown. With no enabled source active the code is 001.
- R4: The interrupt output is high exactly when bit 0 of the identification code is 0.
- R5: Offset 5 reads the line status, laid out as follows. Bit 0 is the live receive-data level. Bits 1 to 4 are sticky overrun, parity, framing and break flags, each set by its strobe. Bit 5 is the live holding-empty level and bit 6 is the live transmitter-idle level. A read of offset 5 clears bits 1 to 4. The line status source is active when its enable is set and any of bits 1 to 4 is 1.
- R6: Offset 6 reads the modem status. Bits 0 to 3 are change flags for CTS, DSR, RI and DCD; each is set on any change of its active-low input pin. Bits 4 to 7 are the inverted pin levels in the same order. A read of offset 6 clears bits 0 to 3. The modem source is active when its enable is set and any change flag is 1.
- R7: A transmit-empty indication is raised when the holding-empty input rises while its enable is set. It is also raised when a write sets the enable from 0 to 1 while the holding register is empty.
- R8: A read of offset 2 that returns 010 withdraws the transmit-empty indication. A read that returns any other code leaves the indication in place.
- R9: The transmit-empty indication is withdrawn when the holding-empty input goes low, or when a write clears its enable.
- R10: A source whose enable bit is 0 does not change the identification code or the interrupt output, though its status bits still record events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 3 | Register offset |
| regWrEn | input | 1 | Write strobe for one cycle |
| regRdEn | input | 1 | Read strobe for one cycle; side effects at the ending edge |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational from regAddr |
| rxDataAvail | input | 1 | Receive FIFO holds at least one byte |
| rxOverrun | input | 1 | Overrun strobe |
| rxParityErr | input | 1 | Parity error strobe |
| rxFrameErr | input | 1 | Framing error strobe |
| rxBreak | input | 1 | Break detected strobe |
| thrEmpty | input | 1 | Transmit holding register empty level |
| txIdle | input | 1 | Transmitter completely empty level |
| ctsN | input | 1 | Clear-to-send pin, active low |
| dsrN | input | 1 | Data-set-ready pin, active low |
| riN | input | 1 | Ring indicator pin, active low |
| dcdN | input | 1 | Carrier detect pin, active low |
| intrOut | output | 1 | Interrupt request, active high |
| intrId | output | 3 | Current identification code |

## Verification
Most internal state in this block can be seen at the ports within one clock. A stuck or lost sticky flag shows up in the line or modem status readback on the next read. It also shows up as a wrong code on intrId. A wrong transmit-empty flag shows either as 010 persisting after the clearing read or the loading of the holding register, or as 010 never appearing after the enable is set while the register is empty. A priority error shows as the wrong code while two sources are held active together. The bench checks every one of these cases in the cycle after the causing edge.

// File: rtl/uart_intr_pkg.sv
package uart_intr_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 8;
  localparam int ID_W     = 3;
  localparam int ENA_W    = 4;

  localparam logic [ADDR_W-1:0] OFF_ENABLE = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_IDENT  = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_LINE   = 3'd5;
  localparam logic [ADDR_W-1:0] OFF_MODEM  = 3'd6;

  localparam logic [ID_W-1:0] ID_NONE  = 3'b001;
  localparam logic [ID_W-1:0] ID_LINE  = 3'b110;
  localparam logic [ID_W-1:0] ID_RX    = 3'b100;
  localparam logic [ID_W-1:0] ID_THR   = 3'b010;
  localparam logic [ID_W-1:0] ID_MODEM = 3'b000;

  typedef struct packed {
    logic ierWr;
    logic idRd;
    logic lsrRd;
    logic msrRd;
  } regStrobeT;
endpackage

// File: rtl/uart_intr_ctrl.sv
module uart_intr_ctrl
  import uart_intr_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              srcLine,
  input  logic              srcRx,
  input  logic              srcThr,
  input  logic              srcModem,
  output regStrobeT         strb,
  output logic [ID_W-1:0]   intrId
);
  always_comb begin
    strb.ierWr = regWrEn && (regAddr == OFF_ENABLE);
    strb.idRd  = regRdEn && (regAddr == OFF_IDENT);
    strb.lsrRd = regRdEn && (regAddr == OFF_LINE);
    strb.msrRd = regRdEn && (regAddr == OFF_MODEM);
  end

  always_comb begin
    if (srcLine)       intrId = ID_LINE;
    else if (srcRx)    intrId = ID_RX;
    else if (srcThr)   intrId = ID_THR;
    else if (srcModem) intrId = ID_MODEM;
    else               intrId = ID_NONE;
  end
endmodule

// File: rtl/uart_intr_dpath.sv
module uart_intr_dpath
  import uart_intr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobeT         strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [ID_W-1:0]   intrId,
  input  logic              rxDataAvail,
  input  logic              rxOverrun,
  input  logic              rxParityErr,
  input  logic              rxFrameErr,
  input  logic              rxBreak,
  input  logic              thrEmpty,
  input  logic              txIdle,
  input  logic [3:0]        modemPinN,
  output logic [DATA_W-1:0] regRdData,
  output logic              srcLine,
  output logic              srcRx,
  output logic              srcThr,
  output logic              srcModem
);
  logic [ENA_W-1:0] ier;
  logic [3:0] lineErr, errSet;
  logic [3:0] modemLvl, modemNow, modemDelta;
  logic thrPend, thrQ, thrSet, thrClr;

  assign errSet   = {rxBreak, rxFrameErr, rxParityErr, rxOverrun};
  assign modemNow = ~modemPinN;

  always_comb begin
    thrSet = (ier[1] && thrEmpty && !thrQ && !(strb.ierWr && !regWrData[1]))
          || (strb.ierWr && regWrData[1] && !ier[1] && thrEmpty);
    thrClr = !thrEmpty
          || (strb.ierWr && !regWrData[1])
          || (strb.idRd && intrId == ID_THR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ier        <= '0;
      lineErr    <= '0;
      modemLvl   <= '0;
      modemDelta <= '0;
      thrPend    <= 1'b0;
      thrQ       <= 1'b1;
    end else begin
      if (strb.ierWr) ier <= regWrData[ENA_W-1:0];
      lineErr    <= (strb.lsrRd ? 4'b0 : lineErr) | errSet;
      modemDelta <= (strb.msrRd ? 4'b0 : modemDelta) | (modemNow ^ modemLvl);
      modemLvl   <= modemNow;
      thrQ       <= thrEmpty;
      if (thrSet)      thrPend <= 1'b1;
      else if (thrClr) thrPend <= 1'b0;
    end
  end

  always_comb begin
    srcLine  = ier[2] && (|lineErr);
    srcRx    = ier[0] && rxDataAvail;
    srcThr   = ier[1] && thrPend;
    srcModem = ier[3] && (|modemDelta);
  end

  always_comb begin
    unique case (regAddr)
      OFF_ENABLE: regRdData = {{(DATA_W-ENA_W){1'b0}}, ier};
      OFF_IDENT:  regRdData = {{(DATA_W-ID_W){1'b0}}, intrId};
      OFF_LINE:   regRdData = {1'b0, txIdle, thrEmpty, lineErr, rxDataAvail};
      OFF_MODEM:  regRdData = {modemLvl, modemDelta};
      default:    regRdData = '0;
    endcase
  end

  AST_LSR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.lsrRd && (errSet == 4'b0) |=> lineErr == 4'b0); // R5
  AST_MSR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.msrRd && (modemNow == modemLvl) |=> modemDelta == 4'b0); // R6
  AST_THR_RAISE_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(thrEmpty) && ier[1] && !strb.ierWr |=> thrPend); // R7
  AST_ID_READ_DROPS_THR: assert property (@(posedge clk) disable iff (!rstN)
    strb.idRd && intrId == ID_THR && !thrSet |=> !thrPend); // R8
  AST_THR_LOAD_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !thrEmpty && !strb.ierWr |=> !thrPend); // R9
endmodule

// File: rtl/uart_intr_ident.sv
module uart_intr_ident
  import uart_intr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              rxDataAvail,
  input  logic              rxOverrun,
  input  logic              rxParityErr,
  input  logic              rxFrameErr,
  input  logic              rxBreak,
  input  logic              thrEmpty,
  input  logic              txIdle,
  input  logic              ctsN,
  input  logic              dsrN,
  input  logic              riN,
  input  logic              dcdN,
  output logic              intrOut,
  output logic [ID_W-1:0]   intrId
);
  regStrobeT strb;
  logic srcLine, srcRx, srcThr, srcModem;

  uart_intr_ctrl u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .srcLine(srcLine), .srcRx(srcRx), .srcThr(srcThr), .srcModem(srcModem),
    .strb(strb), .intrId(intrId)
  );

  uart_intr_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .regWrData(regWrData), .intrId(intrId), .rxDataAvail(rxDataAvail),
    .rxOverrun(rxOverrun), .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr),
    .rxBreak(rxBreak), .thrEmpty(thrEmpty), .txIdle(txIdle),
    .modemPinN({dcdN, riN, dsrN, ctsN}), .regRdData(regRdData),
    .srcLine(srcLine), .srcRx(srcRx), .srcThr(srcThr), .srcModem(srcModem)
  );

  assign intrOut = ~intrId[0];

  AST_INTR_FOLLOWS_ID: assert property (@(posedge clk) disable iff (!rstN)
    intrOut == (intrId != ID_NONE)); // R4
endmodule

// File: tb/uart_intr_ident_bench.sv
module uart_intr_ident_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWrData = '0, regRdData;
  logic rxDataAvail = 1'b0, rxOverrun = 1'b0, rxParityErr = 1'b0, rxFrameErr = 1'b0, rxBreak = 1'b0;
  logic thrEmpty = 1'b1, txIdle = 1'b1;
  logic ctsN = 1'b1, dsrN = 1'b1, riN = 1'b1, dcdN = 1'b1;
  logic intrOut;
  logic [2:0] intrId;

  int nRun = 0, nFail = 0;

  typedef struct { string tag; logic [7:0] exp; } expItemT;
  expItemT expQ[$];
  event rdEv;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_intr_ident u_uart_intr_ident (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .rxDataAvail(rxDataAvail),
    .rxOverrun(rxOverrun), .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr),
    .rxBreak(rxBreak), .thrEmpty(thrEmpty), .txIdle(txIdle), .ctsN(ctsN),
    .dsrN(dsrN), .riN(riN), .dcdN(dcdN), .intrOut(intrOut), .intrId(intrId)
  );

  // monitor: pops expected items and compares against the read bus
  always @(rdEv) begin
    expItemT it;
    it = expQ.pop_front();
    nRun++;
    if (regRdData !== it.exp) begin
      nFail++;
      $display("FAIL %s: read got %02h expected %02h", it.tag, regRdData, it.exp);
    end
  end

  task automatic stepClk();
    @(negedge clk);
  endtask

  task automatic regRead(input logic [2:0] a, input logic [7:0] e, input string tag);
    regAddr = a; regRdEn = 1'b1;
    #1;
    expQ.push_back('{tag, e});
    -> rdEv;
    #1;
    stepClk();
    regRdEn = 1'b0;
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    stepClk();
    regWrEn = 1'b0;
  endtask

  task automatic checkIntr(input logic e, input string tag);
    nRun++;
    if (intrOut !== e) begin
      nFail++;
      $display("FAIL %s: intrOut got %0b expected %0b", tag, intrOut, e);
    end
  endtask

  initial begin
    repeat (3) stepClk();
    rstN = 1'b1;
    stepClk();
    // R1 reset state
    checkIntr(1'b0, "R1 intr");
    regRead(3'd1, 8'h00, "R1 enable");
    regRead(3'd2, 8'h01, "R1 ident");
    regRead(3'd5, 8'h60, "R1 line");
    regRead(3'd6, 8'h00, "R1 modem");
    // R2 enable write, upper bits ignored
    regWrite(3'd1, 8'hF5);
    regRead(3'd1, 8'h05, "R2 enable");
    // R3 receive source, then line status wins
    rxDataAvail = 1'b1; stepClk();
    regRead(3'd2, 8'h04, "R3 rx id");
    checkIntr(1'b1, "R4 intr rx");
    rxOverrun = 1'b1; stepClk(); rxOverrun = 1'b0;
    regRead(3'd2, 8'h06, "R3 line over rx");
    regRead(3'd5, 8'h63, "R5 line overrun");
    regRead(3'd2, 8'h04, "R5 read cleared errors");
    rxDataAvail = 1'b0; stepClk();
    regRead(3'd2, 8'h01, "R3 none");
    checkIntr(1'b0, "R4 intr none");
    // R10 modem change with modem disabled
    ctsN = 1'b0; stepClk(); stepClk();
    regRead(3'd2, 8'h01, "R10 disabled modem");
    checkIntr(1'b0, "R10 intr");
    regRead(3'd6, 8'h11, "R6 cts delta");
    regRead(3'd6, 8'h10, "R6 delta cleared");
    // R7 enable THR while empty; R3 THR over modem; R8
    regWrite(3'd1, 8'h0F);
    riN = 1'b0; stepClk();
    regRead(3'd2, 8'h02, "R7 thr by enable");
    regRead(3'd2, 8'h00, "R8 thr cleared, R3 modem");
    regRead(3'd2, 8'h00, "R8 modem kept");
    regRead(3'd6, 8'h54, "R6 ri delta");
    regRead(3'd2, 8'h01, "R6 after modem read");
    // R7 edge raise, R9 load clears
    thrEmpty = 1'b0; stepClk();
    thrEmpty = 1'b1; stepClk();
    regRead(3'd2, 8'h02, "R7 thr by edge");
    thrEmpty = 1'b0; stepClk();
    regRead(3'd2, 8'h01, "R9 load clears");
    thrEmpty = 1'b1; stepClk();
    checkIntr(1'b1, "R7 intr");
    regWrite(3'd1, 8'h0D);
    regRead(3'd2, 8'h01, "R9 disable clears");
    // R8 read returning other code keeps THR
    rxDataAvail = 1'b1;
    regWrite(3'd1, 8'h0F);
    regRead(3'd2, 8'h04, "R8 rx shown");
    rxDataAvail = 1'b0; stepClk();
    regRead(3'd2, 8'h02, "R8 thr kept");
    regRead(3'd2, 8'h01, "R8 thr dropped");
    // R5 other error strobes, live bits
    rxParityErr = 1'b1; rxFrameErr = 1'b1; rxBreak = 1'b1; stepClk();
    rxParityErr = 1'b0; rxFrameErr = 1'b0; rxBreak = 1'b0;
    txIdle = 1'b0; stepClk();
    regRead(3'd2, 8'h06, "R3 line id");
    regRead(3'd5, 8'h3C, "R5 errors");
    regRead(3'd5, 8'h20, "R5 cleared");
    stepClk();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    nRun++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule